// File: doc/BRIEF.md
# Strap Capture and Power-Down Sequencer

This controller sits beside the synthesizer core of a multi-output clock generator. Right after power-on reset it keeps a set of dual-purpose pins in input mode for a fixed number of reference cycles. During that window it samples the pins into a five-bit strap register. When the window closes it turns the pins into clock outputs. From the frozen straps it derives the active frequency-select code and the graphics-bus speed select. It also returns an inverted copy of the four frequency straps for readback. A register-side source bit can replace the strap code with a five-bit register field.

The second job is an orderly low-power entry and exit. An asynchronous active-low power-down request is synchronized first. Each gated output group is then parked low, and only at a low phase of its own divider, so no high pulse is cut short. Once every group is parked, the oscillator and VCO enables drop together. On release the sequence runs in reverse order:
- the oscillator is re-enabled and given a settle count;
- the VCO is enabled and given a lock count;
- the outputs are ungated, each one at its own low phase.

The CPU and PCI stop requests each gate one group during normal running and have no effect while power-down is in progress.

Top module: `clkgen_ctrl`

## Requirements
- R1: After reset release, `pin_oe_o` stays 0 for exactly POR_CYCLES rising edges and is 1 from then on; every `clk_o` bit is 0 while `pin_oe_o` is 0.
- R2: The strap register takes the value of `strap_i` at each edge inside the window, so it holds the value present at the last edge of the window. Once `pin_oe_o` is 1, later changes on `strap_i` have no effect on the readback or the resolved codes.
- R3: With `src_sel_i`=0, `fs_code_o` is {1'b0, latched strap bits 3:0}. Strap bit 3 maps to FS3 and bit 0 to FS0. With `src_sel_i`=1, `fs_code_o` equals `reg_fs_i`, where bit 4 is the extra select bit and bits 3:0 are the four register select bits.
- R4: `fs_rdbk_o` is the bitwise inverse of latched strap bits 3:0.
- R5: `agp_sel_o` is latched strap bit 4 when `agp_tgl_i`=0, and its inverse when `agp_tgl_i`=1.
- R6: `pd_n_i` passes through a two-flop synchronizer. Power-down entry starts no earlier than the third rising edge after it falls, so `osc_en_o` is still 1 two edges after the fall. A request that is low for a single cycle still starts a full power-down and restart.
- R7: A group's gate changes only while its `phase_i` bit is low. Every high pulse on `clk_o[g]` therefore lasts the full high phase of `phase_i[g]`, including the pulse before parking and the first pulse after restart.
- R8: `osc_en_o` and `vco_en_o` fall together, one edge after all gates are parked. While `osc_en_o` is 0, `vco_en_o` and every `clk_o` bit are 0.
- R9: After `pd_n_i` rises:
  - `osc_en_o` becomes 1 at the third rising edge;
  - `vco_en_o` becomes 1 OSC_CYCLES edges later;
  - every `clk_o` bit stays 0 for a further LOCK_CYCLES edges;
  - ungating then starts.
- R10: In normal running, `cpu_stop_n_i`=0 parks group 0 and `pci_stop_n_i`=0 parks group 1, while the other groups keep running. During power-down both stop inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Power-on reset, active low |
| strap_i | input | 5 | Shared pin levels: [3:0] frequency straps, [4] graphics speed strap |
| pin_oe_o | output | 1 | Shared pins switched to output mode |
| src_sel_i | input | 1 | Frequency source: 0 straps, 1 register field |
| reg_fs_i | input | 5 | Register frequency-select field |
| agp_tgl_i | input | 1 | Invert the latched graphics speed strap |
| fs_code_o | output | 5 | Resolved frequency-select code |
| agp_sel_o | output | 1 | Resolved graphics speed select |
| fs_rdbk_o | output | 4 | Inverted frequency-strap readback |
| pd_n_i | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n_i | input | 1 | Stop request for group 0, active low |
| pci_stop_n_i | input | 1 | Stop request for group 1, active low |
| phase_i | input | NGRP | Free-running divider phase of each output group |
| clk_o | output | NGRP | Gated output clocks |
| osc_en_o | output | 1 | Crystal oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
The bench builds the block with four output groups, each with a different divider period. It uses a six-cycle power-on window, a three-cycle oscillator settle and a five-cycle lock count. The short window allows a fresh reset for every one of the 32 strap patterns, and each pattern is checked against all 32 register codes and both toggle settings. The short settle and lock counts make every edge of the restart sequence checkable exactly. The distinct group periods mean that parking and ungating happen at different cycles for each group, and the pulse-width monitor checks each of those cycles.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;

    localparam int STRAP_W = 5;
    localparam int FS_W    = 4;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_PARK = 3'd1,
        ST_OFF  = 3'd2,
        ST_OSC  = 3'd3,
        ST_LOCK = 3'd4
    } seq_st_e;

endpackage

// File: rtl/cgc_strap_latch.sv
module cgc_strap_latch #(
    parameter int POR_CYCLES = 1024,
    parameter int W          = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] straps_o,
    output logic         done_o
);
    localparam int CW = $clog2(POR_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic [W-1:0]  lat;
    } strap_t;

    strap_t q, d;

    always_comb begin
        d = q;
        if (!q.done) begin
            d.lat = pins_i;
            d.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(POR_CYCLES - 1)) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cnt: '0, done: 1'b0, lat: '0};
        end else begin
            q <= d;
        end
    end

    assign straps_o = q.lat;
    assign done_o   = q.done;

    // R1: once the pins become outputs they never return to input mode
    a_r1_oe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> q.done);

    // R2: latched straps frozen after the window
    a_r2_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> $stable(q.lat));

endmodule

// File: rtl/cgc_freq_resolve.sv
module cgc_freq_resolve
    import clkgen_ctrl_pkg::*;
(
    input  logic [STRAP_W-1:0] straps_i,
    input  logic               src_sel_i,
    input  logic [STRAP_W-1:0] reg_fs_i,
    input  logic               agp_tgl_i,
    output logic [STRAP_W-1:0] fs_code_o,
    output logic               agp_sel_o,
    output logic [FS_W-1:0]    fs_rdbk_o
);
    logic [STRAP_W-1:0] hw_code;

    always_comb begin
        hw_code   = {1'b0, straps_i[FS_W-1:0]};
        fs_code_o = src_sel_i ? reg_fs_i : hw_code;
        agp_sel_o = straps_i[STRAP_W-1] ^ agp_tgl_i;
        fs_rdbk_o = ~straps_i[FS_W-1:0];
    end

endmodule

// File: rtl/cgc_pd_seq.sv
module cgc_pd_seq
    import clkgen_ctrl_pkg::*;
#(
    parameter int NGRP        = 5,
    parameter int OSC_CYCLES  = 512,
    parameter int LOCK_CYCLES = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_done_i,
    input  logic            pd_n_i,
    input  logic            cpu_stop_n_i,
    input  logic            pci_stop_n_i,
    input  logic [NGRP-1:0] phase_i,
    output logic [NGRP-1:0] clk_o,
    output logic            osc_en_o,
    output logic            vco_en_o
);
    localparam int WAIT_MAX = (OSC_CYCLES > LOCK_CYCLES) ? OSC_CYCLES : LOCK_CYCLES;
    localparam int CW       = $clog2(WAIT_MAX + 1);
    localparam int CPU_G    = 0;
    localparam int PCI_G    = 1;

    typedef struct packed {
        seq_st_e         state;
        logic [CW-1:0]   cnt;
        logic [NGRP-1:0] en;
        logic [1:0]      pd_sy;
        logic [1:0]      cpu_sy;
        logic [1:0]      pci_sy;
    } seq_t;

    seq_t            q, d;
    logic [NGRP-1:0] want;

    always_comb begin
        d        = q;
        d.pd_sy  = {q.pd_sy[0], pd_n_i};
        d.cpu_sy = {q.cpu_sy[0], cpu_stop_n_i};
        d.pci_sy = {q.pci_sy[0], pci_stop_n_i};

        want = '0;
        if (q.state == ST_RUN && por_done_i) begin
            want        = '1;
            want[CPU_G] = q.cpu_sy[1];
            want[PCI_G] = q.pci_sy[1];
        end
        for (int g = 0; g < NGRP; g++) begin
            if (!phase_i[g]) begin
                d.en[g] = want[g];
            end
        end

        case (q.state)
            ST_RUN: begin
                if (!q.pd_sy[1]) d.state = ST_PARK;
            end
            ST_PARK: begin
                if (q.en == '0) d.state = ST_OFF;
            end
            ST_OFF: begin
                if (q.pd_sy[1]) begin
                    d.state = ST_OSC;
                    d.cnt   = '0;
                end
            end
            ST_OSC: begin
                if (q.cnt == CW'(OSC_CYCLES - 1)) begin
                    d.state = ST_LOCK;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_LOCK: begin
                if (q.cnt == CW'(LOCK_CYCLES - 1)) begin
                    d.state = ST_RUN;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_RUN, cnt: '0, en: '0,
                   pd_sy: 2'b11, cpu_sy: 2'b11, pci_sy: 2'b11};
        end else begin
            q <= d;
        end
    end

    assign clk_o    = phase_i & q.en;
    assign osc_en_o = (q.state != ST_OFF);
    assign vco_en_o = (q.state == ST_RUN) || (q.state == ST_PARK) || (q.state == ST_LOCK);

    // R6: entry into parking only follows a request seen three edges earlier
    a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.state) == ST_RUN && q.state == ST_PARK) |-> !$past(pd_n_i, 3));

    // R7: gates move only during a low phase
    for (genvar g = 0; g < NGRP; g++) begin : g_gate_chk
        a_r7_gate_at_low: assert property (@(posedge clk) disable iff (!rst_n)
            (q.en[g] != $past(q.en[g])) |-> !$past(phase_i[g]));
    end

    // R8: oscillator only drops once every group was already parked
    a_r8_parked_before_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> ($past(q.en) == '0));

    // R9: VCO is enabled only after the oscillator was already running
    a_r9_osc_before_vco: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en_o) |-> $past(osc_en_o));

    // R10: outputs stay quiet while powered down, whatever the stop inputs do
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_OFF) |-> (q.en == '0 && clk_o == '0));

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
    import clkgen_ctrl_pkg::*;
#(
    parameter int NGRP        = 5,
    parameter int POR_CYCLES  = 1024,
    parameter int OSC_CYCLES  = 512,
    parameter int LOCK_CYCLES = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               pin_oe_o,
    input  logic               src_sel_i,
    input  logic [STRAP_W-1:0] reg_fs_i,
    input  logic               agp_tgl_i,
    output logic [STRAP_W-1:0] fs_code_o,
    output logic               agp_sel_o,
    output logic [FS_W-1:0]    fs_rdbk_o,
    input  logic               pd_n_i,
    input  logic               cpu_stop_n_i,
    input  logic               pci_stop_n_i,
    input  logic [NGRP-1:0]    phase_i,
    output logic [NGRP-1:0]    clk_o,
    output logic               osc_en_o,
    output logic               vco_en_o
);
    logic [STRAP_W-1:0] straps;
    logic               por_done;

    cgc_strap_latch #(.POR_CYCLES(POR_CYCLES), .W(STRAP_W)) u_strap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_i   (strap_i),
        .straps_o (straps),
        .done_o   (por_done)
    );

    cgc_freq_resolve u_freq (
        .straps_i  (straps),
        .src_sel_i (src_sel_i),
        .reg_fs_i  (reg_fs_i),
        .agp_tgl_i (agp_tgl_i),
        .fs_code_o (fs_code_o),
        .agp_sel_o (agp_sel_o),
        .fs_rdbk_o (fs_rdbk_o)
    );

    cgc_pd_seq #(.NGRP(NGRP), .OSC_CYCLES(OSC_CYCLES), .LOCK_CYCLES(LOCK_CYCLES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_done_i   (por_done),
        .pd_n_i       (pd_n_i),
        .cpu_stop_n_i (cpu_stop_n_i),
        .pci_stop_n_i (pci_stop_n_i),
        .phase_i      (phase_i),
        .clk_o        (clk_o),
        .osc_en_o     (osc_en_o),
        .vco_en_o     (vco_en_o)
    );

    assign pin_oe_o = por_done;

endmodule

// File: tb/tb_clkgen_ctrl.sv
module tb_clkgen_ctrl;
    localparam int NGRP = 4;
    localparam int POR  = 6;
    localparam int OSC  = 3;
    localparam int LOCK = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      strap_i = '0;
    logic            pin_oe_o;
    logic            src_sel_i = 1'b0;
    logic [4:0]      reg_fs_i = '0;
    logic            agp_tgl_i = 1'b0;
    logic [4:0]      fs_code_o;
    logic            agp_sel_o;
    logic [3:0]      fs_rdbk_o;
    logic            pd_n_i = 1'b1;
    logic            cpu_stop_n_i = 1'b1;
    logic            pci_stop_n_i = 1'b1;
    logic [NGRP-1:0] phase_i = '0;
    logic [NGRP-1:0] clk_o;
    logic            osc_en_o;
    logic            vco_en_o;

    int errors = 0;
    int checks = 0;
    bit mon_en = 1'b0;
    bit finished = 1'b0;
    int ph = 0;
    int run_len [NGRP];

    clkgen_ctrl #(.NGRP(NGRP), .POR_CYCLES(POR), .OSC_CYCLES(OSC), .LOCK_CYCLES(LOCK)) dut (
        .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .pin_oe_o(pin_oe_o),
        .src_sel_i(src_sel_i), .reg_fs_i(reg_fs_i), .agp_tgl_i(agp_tgl_i),
        .fs_code_o(fs_code_o), .agp_sel_o(agp_sel_o), .fs_rdbk_o(fs_rdbk_o),
        .pd_n_i(pd_n_i), .cpu_stop_n_i(cpu_stop_n_i), .pci_stop_n_i(pci_stop_n_i),
        .phase_i(phase_i), .clk_o(clk_o), .osc_en_o(osc_en_o), .vco_en_o(vco_en_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Divider phases and pulse-width / quiet-state monitor
    always @(negedge clk) begin
        if (mon_en) begin
            for (int g = 0; g < NGRP; g++) begin
                if (clk_o[g]) begin
                    run_len[g]++;
                end else if (run_len[g] != 0) begin
                    chk(run_len[g] == g + 1, "R7 high pulse width", run_len[g], g + 1);
                    run_len[g] = 0;
                end
            end
            if (!osc_en_o) begin
                chk(clk_o == '0 && !vco_en_o, "R8 quiet while oscillator off",
                    int'({vco_en_o, clk_o}), 0);
            end
        end else begin
            for (int g = 0; g < NGRP; g++) run_len[g] = 0;
        end
        #1;
        ph++;
        for (int g = 0; g < NGRP; g++) phase_i[g] = ((ph / (g + 1)) % 2) == 1;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    task automatic power_on(input logic [4:0] s);
        @(negedge clk); #3;
        mon_en = 1'b0;
        rst_n  = 1'b0;
        strap_i = ~s;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 1; k <= POR; k++) begin
            @(negedge clk);
            if (k == 1) strap_i = s;
            if (k == POR - 1) begin
                chk(pin_oe_o == 1'b0, "R1 pins input inside window", pin_oe_o, 0);
                chk(clk_o == '0, "R1 outputs quiet inside window", clk_o, 0);
            end
        end
        chk(pin_oe_o == 1'b1, "R1 pins output after window", pin_oe_o, 1);
        #3 mon_en = 1'b1;
        strap_i = ~s;
    endtask

    int hi_cnt [NGRP];

    task automatic observe(input int n);
        for (int g = 0; g < NGRP; g++) hi_cnt[g] = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int g = 0; g < NGRP; g++) if (clk_o[g]) hi_cnt[g]++;
        end
    endtask

    initial begin
        for (int g = 0; g < NGRP; g++) run_len[g] = 0;

        // Strap capture and frequency resolution, all strap patterns
        for (int s = 0; s < 32; s++) begin
            power_on(5'(s));
            repeat (3) @(negedge clk);
            chk(fs_rdbk_o == ~s[3:0], "R4 inverted readback", fs_rdbk_o, int'(~s[3:0]));
            chk(fs_rdbk_o == ~s[3:0], "R2 straps frozen after window", fs_rdbk_o, int'(~s[3:0]));
            src_sel_i = 1'b0;
            #1 chk(fs_code_o == {1'b0, s[3:0]}, "R3 hardware code", fs_code_o, s % 16);
            agp_tgl_i = 1'b0;
            #1 chk(agp_sel_o == s[4], "R5 agp pass", agp_sel_o, s / 16);
            agp_tgl_i = 1'b1;
            #1 chk(agp_sel_o == !s[4], "R5 agp toggled", agp_sel_o, 1 - s / 16);
            agp_tgl_i = 1'b0;
            src_sel_i = 1'b1;
            for (int r = 0; r < 32; r++) begin
                reg_fs_i = 5'(r);
                #1 chk(fs_code_o == 5'(r), "R3 register code", fs_code_o, r);
            end
            src_sel_i = 1'b0;
        end

        // Normal running and stop requests
        power_on(5'h0A);
        observe(24);
        for (int g = 0; g < NGRP; g++) chk(hi_cnt[g] > 0, "R7 all groups ungated", hi_cnt[g], 1);
        @(negedge clk); cpu_stop_n_i = 1'b0;
        repeat (8) @(negedge clk);
        observe(16);
        chk(hi_cnt[0] == 0, "R10 cpu stop parks group 0", hi_cnt[0], 0);
        chk(hi_cnt[1] > 0 && hi_cnt[2] > 0 && hi_cnt[3] > 0, "R10 other groups run", hi_cnt[2], 1);
        cpu_stop_n_i = 1'b1;
        pci_stop_n_i = 1'b0;
        repeat (8) @(negedge clk);
        observe(16);
        chk(hi_cnt[1] == 0, "R10 pci stop parks group 1", hi_cnt[1], 0);
        chk(hi_cnt[0] > 0 && hi_cnt[3] > 0, "R10 cpu group resumes", hi_cnt[0], 1);
        pci_stop_n_i = 1'b1;
        repeat (8) @(negedge clk);

        // Power-down entry
        pd_n_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(osc_en_o == 1'b1, "R6 two-stage synchronizer delay", osc_en_o, 1);
        begin
            int w = 0;
            while (osc_en_o && w < 40) begin @(negedge clk); w++; end
            chk(!osc_en_o && !vco_en_o, "R8 enables dropped after parking",
                int'({osc_en_o, vco_en_o}), 0);
        end
        // Stop inputs toggled while powered down
        cpu_stop_n_i = 1'b0; pci_stop_n_i = 1'b0;
        repeat (6) @(negedge clk);
        cpu_stop_n_i = 1'b1; pci_stop_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(!osc_en_o && clk_o == '0, "R10 stops ignored in power-down",
            int'({osc_en_o, clk_o}), 0);

        // Release sequence
        pd_n_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(osc_en_o == 1'b0, "R9 oscillator still off after two edges", osc_en_o, 0);
        @(negedge clk);
        chk(osc_en_o && !vco_en_o, "R9 oscillator on at third edge", int'({osc_en_o, vco_en_o}), 2);
        repeat (OSC - 1) @(negedge clk);
        chk(vco_en_o == 1'b0, "R9 VCO waits settle count", vco_en_o, 0);
        @(negedge clk);
        chk(vco_en_o == 1'b1, "R9 VCO enabled after settle", vco_en_o, 1);
        repeat (LOCK) @(negedge clk);
        chk(clk_o == '0, "R9 outputs gated through lock wait", clk_o, 0);
        observe(24);
        for (int g = 0; g < NGRP; g++) chk(hi_cnt[g] > 0, "R9 outputs ungated after lock", hi_cnt[g], 1);

        // Single-cycle power-down request
        @(negedge clk); pd_n_i = 1'b0;
        @(negedge clk); pd_n_i = 1'b1;
        begin
            int w = 0;
            while (osc_en_o && w < 40) begin @(negedge clk); w++; end
            chk(!osc_en_o, "R6 one-cycle request powers down", osc_en_o, 0);
            w = 0;
            while (!vco_en_o && w < 40) begin @(negedge clk); w++; end
            chk(vco_en_o && osc_en_o, "R9 restart after one-cycle request",
                int'({osc_en_o, vco_en_o}), 3);
        end
        observe(24);
        for (int g = 0; g < NGRP; g++) chk(hi_cnt[g] > 0, "R7 groups running again", hi_cnt[g], 1);

        finished = 1'b1;
        summary();
    end

endmodule